// File: doc/BRIEF.md
# Streaming Buffer Flush-Sync Engine

This block is the device-side engine that retires flushes of a streaming DMA buffer. The host posts page-invalidate requests through a register write port, one write per page. The block retires each one after a fixed per-page busy delay, which stands in for dirty-line writeback. The host can also post a sync request that carries the physical address of a completion flag. The host clears that flag in memory before it posts the sync, then polls it. The engine writes a nonzero value to the flag only after every page request accepted before the sync has retired.

Page requests and sync requests share one ordered command queue, so a sync always waits behind the pages posted ahead of it. A sync that arrives while another is still outstanding queues behind it as a separate entry. When the queue is full, the register port drops its ready signal. A control register holds a buffer-enable bit and a diagnostic-enable bit. The host reads this register back after posting writes, to make sure its earlier writes have landed.

Top module: `sbfs_top`

## Requirements
- R1: After reset, reg_ready_o is 1, mem_wr_o and retire_o are 0, rd_valid_o is 0, and rd_data_o is 0.
- R2: A write with reg_sel_i=0 stores reg_wdata_i[1:0] into the control register, with bit 0 as buffer enable and bit 1 as diagnostic enable. A cycle with reg_rd_i=1 makes rd_valid_o 1 for the next cycle, and rd_data_o then shows the control value held before that edge.
- R3: A write with reg_sel_i=1 while buffer enable is 1 queues a page flush. Each page flush holds the engine for PAGE_CYCLES cycles. It then raises retire_o for exactly one cycle, with retire_addr_o equal to the written address with its low PAGE_SHIFT bits cleared. Retirements follow acceptance order.
- R4: A page write accepted while buffer enable is 0 has no effect: no retire_o pulse ever follows from it.
- R5: A write with reg_sel_i=2 whose address has its low 6 bits at zero queues a sync. Its flag write appears on the memory port as mem_wr_o=1, with mem_addr_o equal to that address and mem_data_o equal to FLAG_VALUE, which is nonzero. This happens only after every earlier queued page flush has retired.
- R6: A sync write whose address has any of its low 6 bits set is discarded, and no flag write follows from it.
- R7: While mem_wr_o=1 and mem_ready_i=0, the flag write holds: mem_wr_o stays 1 and mem_addr_o stays unchanged.
- R8: Each accepted sync gives its own flag write, in acceptance order, including syncs posted back to back.
- R9: The queue holds DEPTH commands, counting pages and syncs together. reg_ready_o is 0 exactly when it is full. Any write, including a control write, presented while reg_ready_o is 0 is ignored.
- R10: A write with reg_sel_i=3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Write target: 0 control, 1 page flush, 2 sync, 3 none |
| reg_wdata_i | input | ADDR_W | Write data or address |
| reg_ready_o | output | 1 | Write port can accept (queue not full) |
| reg_rd_i | input | 1 | Control register read strobe |
| rd_valid_o | output | 1 | Read data valid, one cycle after reg_rd_i |
| rd_data_o | output | 2 | Control register read data |
| retire_o | output | 1 | One-cycle pulse when a page flush completes |
| retire_addr_o | output | ADDR_W | Page address of the completing flush |
| mem_wr_o | output | 1 | Completion flag write request |
| mem_addr_o | output | ADDR_W | Completion flag address |
| mem_data_o | output | FLAG_W | Completion flag value |
| mem_ready_i | input | 1 | Memory accepts the flag write |

## Verification
The bench builds the block with DEPTH=8, PAGE_CYCLES=3, PAGE_SHIFT=13, ADDR_W=40 and FLAG_W=64. A queue of eight with a three-cycle page delay fills within a dozen back-to-back writes. This exercises backpressure, dropped control writes while the queue is full, and several syncs queued behind a block of pages. The memory ready line stalls on two cycles out of three during the busy phase, so flag writes are held across several cycles.

// File: rtl/sbfs_pkg.sv
package sbfs_pkg;
  localparam int ALIGN_BITS = 6;
  localparam int CTRL_W = 2;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_PAGE = 2'd1,
    SEL_SYNC = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef enum logic {
    CMD_PAGE = 1'b0,
    CMD_SYNC = 1'b1
  } cmd_kind_e;

  typedef enum logic [1:0] {
    EX_IDLE = 2'd0,
    EX_PAGE = 2'd1,
    EX_FLAG = 2'd2
  } ex_state_e;
endpackage

// File: rtl/sbfs_cmd_fifo.sv
module sbfs_cmd_fifo #(
  parameter int WIDTH = 41,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign head_o  = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= push_data_i;
  end

  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/sbfs_regif.sv
module sbfs_regif
  import sbfs_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int PAGE_SHIFT = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              reg_rd_i,
  input  logic              ready_i,
  output logic              push_o,
  output cmd_kind_e         push_kind_o,
  output logic [ADDR_W-1:0] push_addr_o,
  output logic              rd_valid_o,
  output logic [CTRL_W-1:0] rd_data_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              accept;
  sel_e              sel;

  assign accept = reg_wr_i && ready_i;
  assign sel    = sel_e'(reg_sel_i);

  always_comb begin
    push_o      = 1'b0;
    push_kind_o = CMD_PAGE;
    push_addr_o = '0;
    if (accept) begin
      case (sel)
        SEL_PAGE: begin
          push_o      = ctrl_q[0];
          push_addr_o = {reg_wdata_i[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        end
        SEL_SYNC: begin
          push_o      = (reg_wdata_i[ALIGN_BITS-1:0] == '0);
          push_kind_o = CMD_SYNC;
          push_addr_o = reg_wdata_i;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= reg_rd_i;
      if (reg_rd_i) rd_data_o <= ctrl_q;
      if (accept && sel == SEL_CTRL) ctrl_q <= reg_wdata_i[CTRL_W-1:0];
    end
  end

  assert_rd_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rd_i |=> rd_valid_o);
  assert_blocked_ctrl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && !ready_i) |=> $stable(ctrl_q));
endmodule

// File: rtl/sbfs_exec.sv
module sbfs_exec
  import sbfs_pkg::*;
#(
  parameter int          ADDR_W      = 40,
  parameter int          PAGE_CYCLES = 3,
  parameter int          FLAG_W      = 64,
  parameter logic [63:0] FLAG_VALUE  = 64'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  cmd_kind_e         cmd_kind_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              cmd_pop_o,
  output logic              retire_o,
  output logic [ADDR_W-1:0] retire_addr_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [FLAG_W-1:0] mem_data_o,
  input  logic              mem_ready_i
);
  localparam int CW = (PAGE_CYCLES > 1) ? $clog2(PAGE_CYCLES) : 1;

  ex_state_e         state_q;
  logic [CW-1:0]     cnt_q;
  logic [ADDR_W-1:0] addr_q;

  assign cmd_pop_o     = (state_q == EX_IDLE) && cmd_valid_i;
  assign retire_o      = (state_q == EX_PAGE) && (cnt_q == '0);
  assign retire_addr_o = addr_q;
  assign mem_wr_o      = (state_q == EX_FLAG);
  assign mem_addr_o    = addr_q;
  assign mem_data_o    = FLAG_VALUE[FLAG_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= EX_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        EX_IDLE: if (cmd_valid_i) begin
          addr_q <= cmd_addr_i;
          if (cmd_kind_i == CMD_SYNC) begin
            state_q <= EX_FLAG;
          end else begin
            state_q <= EX_PAGE;
            cnt_q   <= CW'(PAGE_CYCLES - 1);
          end
        end
        EX_PAGE: if (cnt_q == '0) state_q <= EX_IDLE;
                 else             cnt_q   <= cnt_q - 1'b1;
        EX_FLAG: if (mem_ready_i) state_q <= EX_IDLE;
        default: state_q <= EX_IDLE;
      endcase
    end
  end

  assert_flag_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !mem_ready_i) |=> (mem_wr_o && $stable(mem_addr_o)));
  assert_flag_align_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_addr_o[ALIGN_BITS-1:0] == '0));
  assert_flag_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> (mem_data_o != '0));
  assert_retire_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_o |=> !retire_o);
endmodule

// File: rtl/sbfs_top.sv
module sbfs_top
  import sbfs_pkg::*;
#(
  parameter int          ADDR_W      = 40,
  parameter int          PAGE_SHIFT  = 13,
  parameter int          DEPTH       = 8,
  parameter int          PAGE_CYCLES = 3,
  parameter int          FLAG_W      = 64,
  parameter logic [63:0] FLAG_VALUE  = 64'd1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic              reg_ready_o,
  input  logic              reg_rd_i,
  output logic              rd_valid_o,
  output logic [1:0]        rd_data_o,
  output logic              retire_o,
  output logic [ADDR_W-1:0] retire_addr_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [FLAG_W-1:0] mem_data_o,
  input  logic              mem_ready_i
);
  localparam int ENTRY_W = ADDR_W + 1;

  logic              push, pop, empty, full;
  cmd_kind_e         push_kind;
  logic [ADDR_W-1:0] push_addr;
  logic [ENTRY_W-1:0] head;

  assign reg_ready_o = !full;

  sbfs_regif #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_sel_i   (reg_sel_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rd_i    (reg_rd_i),
    .ready_i     (reg_ready_o),
    .push_o      (push),
    .push_kind_o (push_kind),
    .push_addr_o (push_addr),
    .rd_valid_o  (rd_valid_o),
    .rd_data_o   (rd_data_o)
  );

  sbfs_cmd_fifo #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i ({push_kind, push_addr}),
    .pop_i       (pop),
    .head_o      (head),
    .empty_o     (empty),
    .full_o      (full)
  );

  sbfs_exec #(
    .ADDR_W(ADDR_W), .PAGE_CYCLES(PAGE_CYCLES), .FLAG_W(FLAG_W), .FLAG_VALUE(FLAG_VALUE)
  ) u_exec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_valid_i   (!empty),
    .cmd_kind_i    (cmd_kind_e'(head[ADDR_W])),
    .cmd_addr_i    (head[ADDR_W-1:0]),
    .cmd_pop_o     (pop),
    .retire_o      (retire_o),
    .retire_addr_o (retire_addr_o),
    .mem_wr_o      (mem_wr_o),
    .mem_addr_o    (mem_addr_o),
    .mem_data_o    (mem_data_o),
    .mem_ready_i   (mem_ready_i)
  );
endmodule

// File: tb/sim_sbfs_top.sv
module sim_sbfs_top;
  localparam int AW = 40;
  localparam int PS = 13;
  localparam int DEPTH = 8;
  localparam int PC = 3;
  localparam int FW = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, mem_rdy = 1'b1;
  logic [1:0] sel = 2'd0;
  logic [AW-1:0] wdata = '0;
  logic ready, rd_valid, retire, mem_wr;
  logic [1:0] rd_data;
  logic [AW-1:0] retire_addr, mem_addr;
  logic [FW-1:0] mem_data;

  int total = 0, bad = 0, cyc = 0;
  bit stall_mode = 1'b0;
  bit in_reset = 1'b1;

  always #2.5 clk = ~clk;

  sbfs_top #(.ADDR_W(AW), .PAGE_SHIFT(PS), .DEPTH(DEPTH), .PAGE_CYCLES(PC), .FLAG_W(FW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wdata),
    .reg_ready_o(ready), .reg_rd_i(rd), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .retire_o(retire), .retire_addr_o(retire_addr), .mem_wr_o(mem_wr),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ready_i(mem_rdy)
  );

  // behavioural reference: command queue plus engine state
  logic [AW:0] q[$];
  int m_state = 0, m_cnt = 0;
  logic [AW-1:0] m_addr = '0;
  logic [1:0] m_ctrl = 2'd0, m_rd_data = 2'd0;
  logic m_rd_valid = 1'b0;
  int m_retires = 0, m_flags = 0, d_retires = 0, d_flags = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_state = 0; m_cnt = 0; m_addr = '0;
      m_ctrl = 2'd0; m_rd_data = 2'd0; m_rd_valid = 1'b0;
    end else begin
      logic acc;
      logic [1:0] c;
      logic [AW:0] e;
      acc = wr && (q.size() < DEPTH);
      c = m_ctrl;
      m_rd_valid = rd;
      if (rd) m_rd_data = c;
      if (m_state == 2 && mem_rdy) m_flags++;
      if (m_state == 1 && m_cnt == 0) m_retires++;
      case (m_state)
        0: if (q.size() > 0) begin
          e = q.pop_front();
          m_addr = e[AW-1:0];
          if (e[AW]) m_state = 2;
          else begin m_state = 1; m_cnt = PC - 1; end
        end
        1: if (m_cnt == 0) m_state = 0; else m_cnt--;
        default: if (mem_rdy) m_state = 0;
      endcase
      if (acc) begin
        case (sel)
          2'd0: m_ctrl = wdata[1:0];
          2'd1: if (c[0]) q.push_back({1'b0, wdata[AW-1:PS], {PS{1'b0}}});
          2'd2: if (wdata[5:0] == 6'd0) q.push_back({1'b1, wdata});
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!in_reset) begin
      cyc++;
      chk("R9 ready", 64'(ready), 64'(q.size() < DEPTH));
      chk("R3 retire", 64'(retire), 64'(m_state == 1 && m_cnt == 0));
      if (retire) chk("R3 retire_addr", 64'(retire_addr), 64'(m_addr));
      chk("R5 mem_wr", 64'(mem_wr), 64'(m_state == 2));
      if (mem_wr) begin
        chk("R7 mem_addr", 64'(mem_addr), 64'(m_addr));
        chk("R5 mem_data", mem_data, 64'd1);
      end
      chk("R2 rd_valid", 64'(rd_valid), 64'(m_rd_valid));
      chk("R2 rd_data", 64'(rd_data), 64'(m_rd_data));
      if (retire) d_retires++;
      if (mem_wr && mem_rdy) d_flags++;
    end
  end

  always @(posedge clk) begin
    #1;
    mem_rdy = stall_mode ? (cyc % 3 == 2) : 1'b1;
  end

  task automatic drive(input bit w, input logic [1:0] s, input logic [AW-1:0] d, input bit r);
    @(posedge clk); #1;
    wr = w; sel = s; wdata = d; rd = r;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'd0, '0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 64'(ready), 64'd1);
    chk("R1 mem_wr", 64'(mem_wr), 64'd0);
    chk("R1 retire", 64'(retire), 64'd0);
    chk("R1 rd", 64'({rd_valid, rd_data}), 64'd0);
    in_reset = 1'b0;

    // R4: page while disabled is dropped
    drive(1'b1, 2'd1, 40'h00_1234_5678, 1'b0);
    drive(1'b0, 2'd0, '0, 1'b1);
    idle(8);
    chk("R4 no retire", 64'(d_retires), 64'd0);

    // R2: enable and read back
    drive(1'b1, 2'd0, 40'h3, 1'b0);
    drive(1'b0, 2'd0, '0, 1'b1);
    drive(1'b1, 2'd0, 40'h1, 1'b1);
    drive(1'b0, 2'd0, '0, 1'b1);
    idle(2);

    // R3 R5 R6 R10: pages then syncs, misaligned sync, unused select
    drive(1'b1, 2'd1, 40'h00_0000_2fff, 1'b0);
    drive(1'b1, 2'd1, 40'h00_0001_4001, 1'b0);
    drive(1'b1, 2'd1, 40'h12_3456_7abc, 1'b0);
    drive(1'b1, 2'd2, 40'h00_1000_0040, 1'b0);
    drive(1'b1, 2'd1, 40'h00_0000_6000, 1'b0);
    drive(1'b1, 2'd2, 40'h00_2000_0041, 1'b0);
    drive(1'b1, 2'd3, 40'h00_3000_0000, 1'b0);
    idle(40);
    chk("R6 one flag", 64'(d_flags), 64'd1);
    chk("R3 four retires", 64'(d_retires), 64'd4);

    // R9 R8 R7: fill queue, blocked control write, back-to-back syncs with stalls
    stall_mode = 1'b1;
    for (int i = 0; i < 12; i++) drive(1'b1, 2'd1, 40'(i) << PS, 1'b0);
    drive(1'b1, 2'd0, 40'h0, 1'b0);
    drive(1'b1, 2'd2, 40'h00_4000_0000, 1'b0);
    drive(1'b1, 2'd2, 40'h00_4000_0080, 1'b0);
    drive(1'b1, 2'd2, 40'h00_4000_00c0, 1'b0);
    drive(1'b0, 2'd0, '0, 1'b1);
    idle(150);
    chk("R8 flag total", 64'(d_flags), 64'(m_flags));
    chk("R3 retire total", 64'(d_retires), 64'(m_retires));

    // R4 R5: disable, sync still completes
    stall_mode = 1'b0;
    drive(1'b1, 2'd0, 40'h2, 1'b0);
    drive(1'b1, 2'd1, 40'h00_0000_8000, 1'b1);
    drive(1'b1, 2'd2, 40'h00_5000_0000, 1'b0);
    idle(20);
    chk("R8 flag total end", 64'(d_flags), 64'(m_flags));
    chk("R4 retire total end", 64'(d_retires), 64'(m_retires));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule